// File: doc/BRIEF.md
# Halfword-Swapping DMA Burst Mover

This block moves data between the buffer of a 16-bit network peripheral and a big-endian system memory. The peripheral asks for a transfer with one start pulse that carries a byte offset, a byte length, a direction and a swap flag. The engine forms the memory address by OR-ing the offset with a base value given on its own input. It then issues one memory beat for each halfword. When the swap flag is set, the two bytes of every halfword are exchanged on the way through, in both directions.

Reads run from memory to the peripheral. Each halfword is fetched over the memory port and then offered on an outgoing stream. Writes run from the peripheral to memory. Unswapped writes go straight from the incoming stream to the memory port. Swapped writes are staged in a 32-halfword (64-byte) buffer one chunk at a time. A chunk is filled from the stream and then drained to memory, and the address keeps advancing until the whole length is done.

All three data interfaces use valid/ready. A beat moves on a clock edge where valid and ready are both high. A valid that is held by the engine is never withdrawn, and its payload stays stable until ready is seen. The engine accepts any ready pattern from memory and from the peripheral. Start, busy, done and the error flag are plain level and pulse signals.

Top module: `hws_dma`

## Requirements
- R1: Memory beat k of a transfer (counting from 0) uses the address (req_addr | base_addr) + 2*k. The OR is bitwise, not an addition.
- R2: With req_swap = 0, halfwords pass unchanged in both directions: from mem_rdata to dst_data, and from src_data to mem_wdata.
- R3: With req_swap = 1 on a read (req_write = 0), each halfword fetched from memory is presented on dst_data with its bytes exchanged: bits [15:8] and [7:0] trade places.
- R4: With req_swap = 1 on a write (req_write = 1), each halfword taken from src_data is written to memory with its bytes exchanged.
- R5: A swapped write works in chunks of at most CHUNK_HW = 32 halfwords. Memory beat k is not issued until the source has delivered min(total, (k/32 + 1)*32) halfwords. While a chunk is filling, no memory beat is issued.
- R6: A swapped transfer with an odd req_len moves floor(req_len/2) halfwords and leaves the trailing byte untouched. It raises err_odd in the same cycle as done. err_odd is never high at any other time.
- R7: An unswapped transfer with an odd req_len moves ceil(req_len/2) halfwords. Its last memory beat has mem_be = 2'b10, which means only bits [15:8] (the byte at the lower address) are valid. All other beats have mem_be = 2'b11. No error is flagged.
- R8: done is high for exactly one cycle. That cycle directly follows the last beat handshake: the last memory handshake for a write, or the last dst handshake for a read.
- R9: busy is high from the cycle after an accepted start through the done cycle. A start pulse while busy is high is ignored and does not change the transfer in flight.
- R10: Back-pressure: while dst_valid is high and dst_ready is low, dst_valid stays high and dst_data is stable. A read beat held on the memory port keeps mem_valid high and mem_addr stable until mem_ready.
- R11: A transfer whose beat count is zero issues no beats and asserts done in the cycle after start. This covers req_len = 0, and req_len = 1 with swapping.
- R12: After reset, busy, done, err_odd, mem_valid, dst_valid and src_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; sampled only while idle |
| req_write | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| req_swap | input | 1 | Exchange the bytes of every halfword |
| req_addr | input | ADDR_W | Byte offset of the transfer |
| req_len | input | LEN_W | Transfer length in bytes |
| base_addr | input | ADDR_W | Base value OR-ed into the offset |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_odd | output | 1 | Odd length with swapping, valid with done |
| src_valid | input | 1 | Peripheral write data valid |
| src_ready | output | 1 | Engine accepts write data |
| src_data | input | 16 | Write halfword from the peripheral |
| dst_valid | output | 1 | Read halfword valid |
| dst_ready | input | 1 | Peripheral accepts read data |
| dst_data | output | 16 | Read halfword to the peripheral |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat; mem_rdata valid on reads |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_be | output | 2 | Byte enables; bit 1 covers [15:8] |
| mem_wdata | output | 16 | Write halfword |
| mem_rdata | input | 16 | Read halfword, valid with mem_ready |

## Verification
The bench builds the block with its defaults: ADDR_W = 24, LEN_W = 12 and CHUNK_HW = 32. Lengths of up to 80 bytes therefore cross the 32-halfword chunk boundary, and both a full chunk followed by a short tail and a single short chunk occur. A base of 0x400 combined with offsets above 0x400 makes an OR that was replaced by an addition show up as a wrong address. Random wait states on all three streams exercise the stall and hold rules at every point of both read and write flows.

// File: rtl/hws_pkg.sv
`timescale 1ns/1ps
package hws_pkg;
  localparam int HW_W = 16;
  localparam int HW_BYTES = HW_W / 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RREQ,
    S_ROUT,
    S_WDIR,
    S_FILL,
    S_DRAIN,
    S_DONE
  } hws_state_t;
endpackage

// File: rtl/hws_swap.sv
`timescale 1ns/1ps
module hws_swap
  import hws_pkg::*;
#(
  parameter int W = HW_W
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  logic [W-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/hws_stage.sv
`timescale 1ns/1ps
module hws_stage #(
  parameter int DEPTH = 32,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/hws_dma.sv
`timescale 1ns/1ps
module hws_dma
  import hws_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 12,
  parameter int CHUNK_HW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic              req_swap,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              err_odd,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [HW_W-1:0]   src_data,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [HW_W-1:0]   dst_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [HW_BYTES-1:0] mem_be,
  output logic [HW_W-1:0]   mem_wdata,
  input  logic [HW_W-1:0]   mem_rdata
);
  localparam int CW = $clog2(CHUNK_HW + 1);
  localparam int BW = $clog2(CHUNK_HW);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(HW_BYTES);

  hws_state_t        state;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  left;
  logic [CW-1:0]     cnum, cidx;
  logic              wr_q, sw_q, err_q, part_q;
  logic [HW_W-1:0]   hold, rd_sw, wr_sw, stage_q;
  logic [LEN_W-1:0]  nbeats;
  logic              last_in_chunk, last_beat;

  function automatic logic [CW-1:0] chunk_of(input logic [LEN_W-1:0] n);
    if (n >= LEN_W'(CHUNK_HW)) return CW'(CHUNK_HW);
    return CW'(n);
  endfunction

  assign nbeats = req_swap ? (req_len >> 1)
                           : ((req_len >> 1) + LEN_W'(req_len[0]));
  assign last_in_chunk = (cidx == cnum - CW'(1));
  assign last_beat     = (left == LEN_W'(1));

  hws_swap #(.W(HW_W)) u_rsw (.en(sw_q), .din(mem_rdata), .dout(rd_sw));
  hws_swap #(.W(HW_W)) u_wsw (.en(sw_q), .din(src_data),  .dout(wr_sw));

  hws_stage #(.DEPTH(CHUNK_HW), .W(HW_W)) u_stage (
    .clk   (clk),
    .we    (state == S_FILL && src_valid),
    .waddr (cidx[BW-1:0]),
    .wdata (wr_sw),
    .raddr (cidx[BW-1:0]),
    .rdata (stage_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      left   <= '0;
      cnum   <= '0;
      cidx   <= '0;
      wr_q   <= 1'b0;
      sw_q   <= 1'b0;
      err_q  <= 1'b0;
      part_q <= 1'b0;
      hold   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          wr_q   <= req_write;
          sw_q   <= req_swap;
          err_q  <= req_swap & req_len[0];
          part_q <= ~req_swap & req_len[0];
          cur    <= req_addr | base_addr;
          left   <= nbeats;
          cidx   <= '0;
          cnum   <= chunk_of(nbeats);
          if (nbeats == '0)   state <= S_DONE;
          else if (!req_write) state <= S_RREQ;
          else if (req_swap)   state <= S_FILL;
          else                 state <= S_WDIR;
        end
        S_RREQ: if (mem_ready) begin
          hold  <= rd_sw;
          state <= S_ROUT;
        end
        S_ROUT: if (dst_ready) begin
          cur   <= cur + STEP;
          left  <= left - LEN_W'(1);
          state <= last_beat ? S_DONE : S_RREQ;
        end
        S_WDIR: if (src_valid && mem_ready) begin
          cur  <= cur + STEP;
          left <= left - LEN_W'(1);
          if (last_beat) state <= S_DONE;
        end
        S_FILL: if (src_valid) begin
          if (last_in_chunk) begin
            cidx  <= '0;
            state <= S_DRAIN;
          end else begin
            cidx <= cidx + CW'(1);
          end
        end
        S_DRAIN: if (mem_ready) begin
          cur  <= cur + STEP;
          left <= left - LEN_W'(1);
          if (last_in_chunk) begin
            cidx <= '0;
            if (last_beat) begin
              state <= S_DONE;
            end else begin
              cnum  <= chunk_of(left - LEN_W'(1));
              state <= S_FILL;
            end
          end else begin
            cidx <= cidx + CW'(1);
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign err_odd   = done & err_q;
  assign src_ready = (state == S_FILL) || (state == S_WDIR && mem_ready);
  assign dst_valid = (state == S_ROUT);
  assign dst_data  = hold;
  assign mem_valid = (state == S_RREQ) || (state == S_DRAIN)
                  || (state == S_WDIR && src_valid);
  assign mem_we    = wr_q;
  assign mem_addr  = cur;
  assign mem_wdata = (state == S_DRAIN) ? stage_q : wr_sw;
  assign mem_be    = (part_q && last_beat) ? 2'b10 : 2'b11;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_odd |-> done);

  // R10
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we)
      |=> (done || (mem_addr == $past(mem_addr) + STEP)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && sw_q && wr_q) |-> !mem_valid);
endmodule

// File: tb/sim_hws_dma.sv
`timescale 1ns/1ps
module sim_hws_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, req_write = 1'b0, req_swap = 1'b0;
  logic [23:0] req_addr = '0, base_addr = '0;
  logic [11:0] req_len = '0;
  logic busy, done, err_odd;
  logic src_valid = 1'b0, src_ready;
  logic [15:0] src_data = '0;
  logic dst_valid, dst_ready = 1'b0;
  logic [15:0] dst_data;
  logic mem_valid, mem_ready = 1'b0, mem_we;
  logic [23:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata = '0;

  always #10 clk = ~clk;

  hws_dma u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] mem [512];
  logic [15:0] pre [512];
  logic [15:0] srcq [256];
  logic [15:0] got [256];
  int nb = 0, src_idx = 0, mem_k = 0, dst_k = 0, viol = 0, addr_bad = 0;
  int done_cnt = 0, done_cyc = 0, last_hs_cyc = 0, start_cyc = 0;
  bit err_seen = 0, act_chunked = 0;
  logic [23:0] exp_start = '0;

  function automatic logic [15:0] bsw(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // stream and memory models: drive at negedge, settle, then record handshakes
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready = ($urandom_range(0, 99) < 65);
      dst_ready = ($urandom_range(0, 99) < 60);
      src_valid = (src_idx < nb) && ($urandom_range(0, 99) < 70);
      src_data  = srcq[src_idx[7:0]];
      #1;
      mem_rdata = mem[mem_addr[9:1]];
      if (mem_valid && mem_ready) begin
        if (mem_addr != exp_start + 24'(2 * mem_k)) addr_bad++;
        if (mem_we) begin
          if (mem_be[1]) mem[mem_addr[9:1]][15:8] = mem_wdata[15:8];
          if (mem_be[0]) mem[mem_addr[9:1]][7:0]  = mem_wdata[7:0];
          if (act_chunked) begin
            int need;
            need = ((mem_k / 32) + 1) * 32;
            if (need > nb) need = nb;
            if (src_idx < need) viol++;
          end
          last_hs_cyc = cyc;
        end
        mem_k++;
      end
      if (src_valid && src_ready) src_idx++;
      if (dst_valid && dst_ready) begin
        got[dst_k[7:0]] = dst_data;
        dst_k++;
        last_hs_cyc = cyc;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        err_seen = err_odd;
      end
    end
  end

  task automatic xfer(input bit w, input bit s, input logic [23:0] a,
                      input int len, input logic [23:0] base, input bit poke);
    int nbx, idx, bad, t;
    logic [15:0] e;
    string rq;
    nbx = s ? len / 2 : (len + 1) / 2;
    for (int i = 0; i < 512; i++) pre[i] = mem[i];
    for (int i = 0; i < 256; i++) srcq[i] = 16'($urandom);
    exp_start = a | base;
    idx = int'(exp_start[9:1]);
    src_idx = 0; mem_k = 0; dst_k = 0; viol = 0; addr_bad = 0; done_cnt = 0;
    err_seen = 0;
    nb = w ? nbx : 0;
    act_chunked = w && s;
    @(negedge clk);
    start = 1'b1; req_write = w; req_swap = s; req_addr = a;
    req_len = 12'(len); base_addr = base;
    #2 start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    #2;
    if (nbx > 0) chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    t = 0;
    while (done_cnt == 0 && t < 5000) begin
      @(negedge clk);
      t++;
      if (poke && t == 2) begin
        start = 1'b1; req_write = ~w; req_len = 12'd4; req_addr = 24'h100;
      end
      if (poke && t == 3) start = 1'b0;
    end
    repeat (4) @(negedge clk);
    #2;
    chk(t < 5000, "R8", "transfer completes", t, 5000);
    chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
    chk(busy == 1'b0, "R9", "idle after done", int'(busy), 0);
    chk(addr_bad == 0 && mem_k == nbx, "R1", "beat addresses/count", mem_k, nbx);
    if (nbx > 0)
      chk(done_cyc == last_hs_cyc + 1, "R8", "done timing", done_cyc, last_hs_cyc + 1);
    else
      chk(done_cyc == start_cyc + 1, "R11", "empty done timing", done_cyc, start_cyc + 1);
    rq = s ? "R6" : "R7";
    chk(err_seen == (s && (len % 2 == 1)), rq, "odd-length flag",
        int'(err_seen), int'(s && (len % 2 == 1)));
    bad = 0;
    if (!w) begin
      rq = s ? "R3" : "R2";
      chk(dst_k == nbx, rq, "read beats delivered", dst_k, nbx);
      for (int i = 0; i < nbx; i++) begin
        e = s ? bsw(pre[(idx + i) % 512]) : pre[(idx + i) % 512];
        if (got[i] !== e) bad++;
      end
      chk(bad == 0, rq, "read data", bad, 0);
    end else begin
      for (int i = 0; i < nbx; i++) begin
        e = s ? bsw(srcq[i]) : srcq[i];
        if (!s && (len % 2 == 1) && i == nbx - 1) e[7:0] = pre[(idx + i) % 512][7:0];
        pre[(idx + i) % 512] = e;
      end
      for (int i = 0; i < 512; i++) if (mem[i] !== pre[i]) bad++;
      rq = s ? "R4" : ((len % 2 == 1) ? "R7" : "R2");
      chk(bad == 0, rq, "memory image after write", bad, 0);
      if (s) chk(viol == 0, "R5", "chunk staged before drain", viol, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", 190000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    #2;
    // R12: reset state
    chk(!busy && !done && !err_odd && !mem_valid && !dst_valid && !src_ready,
        "R12", "reset outputs", {busy, done, err_odd, mem_valid, dst_valid, src_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    xfer(1'b0, 1'b1, 24'h020, 8,  24'h400, 1'b0);  // R3 swapped read
    xfer(1'b0, 1'b0, 24'h040, 10, 24'h400, 1'b0);  // R2 plain read
    xfer(1'b1, 1'b0, 24'h060, 7,  24'h400, 1'b0);  // R7 odd plain write
    xfer(1'b1, 1'b1, 24'h080, 70, 24'h400, 1'b0);  // R5 two chunks
    xfer(1'b1, 1'b1, 24'h100, 64, 24'h400, 1'b0);  // R5 exact chunk
    xfer(1'b1, 1'b1, 24'h140, 5,  24'h400, 1'b0);  // R6 odd swapped write
    xfer(1'b0, 1'b1, 24'h160, 3,  24'h400, 1'b0);  // R6 odd swapped read
    xfer(1'b0, 1'b0, 24'h180, 0,  24'h400, 1'b0);  // R11 empty
    xfer(1'b1, 1'b1, 24'h180, 1,  24'h400, 1'b0);  // R11 swap, one byte
    xfer(1'b0, 1'b0, 24'h620, 6,  24'h400, 1'b0);  // R1 OR not add
    xfer(1'b0, 1'b1, 24'h1a0, 12, 24'h400, 1'b1);  // R9 start while busy
    xfer(1'b1, 1'b0, 24'h1c0, 8,  24'h400, 1'b1);  // R9 start while busy

    for (int n = 0; n < 24; n++) begin
      xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           24'($urandom_range(0, 384) * 2), $urandom_range(0, 80), 24'h400, 1'b0);
    end
    summary();
    $finish;
  end
endmodule